// File: doc/BRIEF.md
# Coin Telephone Call Controller

This block sequences one call on a coin-operated public telephone. It watches the hook switch, a coin-detect input, three line-status levels (busy, connected, faulted) and a once-per-second tick. From these it produces the control levels for the handset path and the customer indicators. These are: enable of the talk path, a prompt asking for a further coin, a single-cycle coin-return pulse, a single-cycle call-ended pulse, and an out-of-order indication.

A coin buys a fixed talk slot of `SLOT_S` seconds. After `PROMPT_S` seconds of a slot the prompt rises. A coin dropped while the prompt is up starts a fresh slot. If no coin arrives, the slot runs out and the call ends. The controller then waits for the receiver to be hung up. A line fault takes precedence over every other condition, returns a coin that has not yet been spent, and holds the unit out of order. The unit leaves that state only when the fault has gone and the receiver is on the hook. A generate option selects whether a coin is counted on the rising edge of `coin_in` or on every cycle it is high.

Top module: `payphone_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, all five outputs are low and the unit is idle.
- R2: Lifting the receiver and then inserting a coin holds the coin. With the default edge option, a coin input held high for several cycles counts as one coin. A later `line_connected` (with `line_busy` low) raises `call_enable` on the cycle after the clock edge that samples it.
- R3: A held coin that meets `line_busy` never enables the call. When the receiver is then hung up, `coin_return` pulses for exactly one cycle and the unit becomes idle.
- R4: `insert_coin_prompt` rises once `PROMPT_S` ticks have been counted in the current slot. It stays high until the slot ends or a coin restarts the slot, and it is never high outside a call.
- R5: A coin arriving while the prompt is high restarts the slot from zero seconds and clears the prompt. A coin arriving in a slot before the prompt has no effect on slot timing.
- R6: When the `SLOT_S`-th tick of a slot arrives with no coin in that cycle, `call_terminate` pulses for one cycle and `call_enable` falls. The unit then ignores line and coin inputs until the receiver goes on-hook, and only returns to idle at that point.
- R7: Going on-hook in any call state (other than out of order) returns the unit to idle. If the unit was talking, `call_enable` falls on the next cycle.
- R8: A high `line_fault` puts the unit out of order on the next cycle from any state, and this outranks an on-hook in the same cycle. `coin_return` pulses if a coin was held and not yet spent. While out of order, the call, prompt and terminate outputs stay low.
- R9: The unit leaves the out-of-order state, to idle, only in a cycle where `line_fault` is low and the receiver is on-hook.
- R10: The slot counter only advances on `tick_1s` while talking. A tick in the cycle a call connects is not counted. When a coin and the final tick of a slot coincide, the coin wins and the call continues.
- R11: Coin and line inputs while idle, with the receiver on the hook, have no effect. A subsequent off-hook still requires a new coin before a call can connect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-cycle pulse per second |
| off_hook | input | 1 | High while the receiver is lifted |
| coin_in | input | 1 | Coin detector |
| line_busy | input | 1 | Called line is busy |
| line_connected | input | 1 | Called line has answered |
| line_fault | input | 1 | Line fault present |
| coin_return | output | 1 | One-cycle pulse ejecting the held coin |
| call_enable | output | 1 | Talk path enabled |
| insert_coin_prompt | output | 1 | Request for a further coin |
| call_terminate | output | 1 | One-cycle pulse when the slot runs out |
| out_of_order | output | 1 | Unit is out of order |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a coin and the last tick of a slot. The second pair is a line fault and an on-hook, and in the busy case these two events also decide whether the coin comes back. The bench drives a coin pulse in exactly the cycle that carries the `SLOT_S`-th tick, and it drops the hook in the same cycle that raises the fault, both while talking and while a coin is held. A behavioural model predicts every output on every cycle and rules that the coin extends the call and that the fault outranks the hook. A missing terminate pulse, a late out-of-order indication or a wrong coin return therefore shows up in the cycle it occurs.

// File: rtl/payphone_pkg.sv
package payphone_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_NEED_COIN = 3'd1,
      ST_COIN_HELD = 3'd2,
      ST_LINE_BUSY = 3'd3,
      ST_TALK      = 3'd4,
      ST_DONE      = 3'd5,
      ST_FAULT     = 3'd6
   } call_state_t;

   function automatic logic coin_is_held(call_state_t s);
      return (s == ST_COIN_HELD) || (s == ST_LINE_BUSY);
   endfunction

endpackage

// File: rtl/pp_slot_timer.sv
module pp_slot_timer #(
   parameter int SLOT_S   = 60,
   parameter int PROMPT_S = 45
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic tick,
   input  logic restart,
   output logic prompt,
   output logic expire
);
   localparam int CNT_W = (SLOT_S > 2) ? $clog2(SLOT_S) : 1;
   localparam logic [CNT_W-1:0] LAST      = CNT_W'(SLOT_S - 1);
   localparam logic [CNT_W-1:0] PROMPT_AT = CNT_W'(PROMPT_S);

   logic [CNT_W-1:0] secs;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         secs <= '0;
      end else if (restart) begin
         secs <= '0;
      end else if (tick) begin
         secs <= (secs == LAST) ? '0 : secs + 1'b1;
      end
   end

   assign expire = run & tick & ~restart & (secs == LAST);
   assign prompt = run & (secs >= PROMPT_AT);

   AST_SECS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      secs <= LAST);                                            // R10
   AST_CLEAR_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
      !run |=> secs == '0);                                     // R10
   AST_PROMPT_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
      prompt |-> run);                                          // R4
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (run && restart) |=> !prompt);                            // R5

endmodule

// File: rtl/pp_call_fsm.sv
module pp_call_fsm
   import payphone_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic off_hook,
   input  logic coin_evt,
   input  logic line_busy,
   input  logic line_connected,
   input  logic line_fault,
   input  logic slot_prompt,
   input  logic slot_expire,
   output logic slot_run,
   output logic slot_restart,
   output logic coin_return,
   output logic call_enable,
   output logic call_terminate,
   output logic out_of_order
);
   call_state_t state, state_n;
   logic        ret_n, term_n;
   logic        ret_q, term_q;

   assign slot_run     = (state == ST_TALK);
   assign slot_restart = slot_run & coin_evt & slot_prompt;

   always_comb begin
      state_n = state;
      ret_n   = 1'b0;
      term_n  = 1'b0;
      if (line_fault) begin
         ret_n   = coin_is_held(state);
         state_n = ST_FAULT;
      end else begin
         case (state)
            ST_FAULT: if (!off_hook) state_n = ST_IDLE;
            ST_IDLE:  if (off_hook)  state_n = ST_NEED_COIN;
            default: begin
               if (!off_hook) begin
                  ret_n   = coin_is_held(state);
                  state_n = ST_IDLE;
               end else begin
                  case (state)
                     ST_NEED_COIN: if (coin_evt) state_n = ST_COIN_HELD;
                     ST_COIN_HELD: begin
                        if (line_busy)           state_n = ST_LINE_BUSY;
                        else if (line_connected) state_n = ST_TALK;
                     end
                     ST_TALK: begin
                        if (slot_expire) begin
                           term_n  = 1'b1;
                           state_n = ST_DONE;
                        end
                     end
                     default: state_n = state;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         ret_q  <= 1'b0;
         term_q <= 1'b0;
      end else begin
         state  <= state_n;
         ret_q  <= ret_n;
         term_q <= term_n;
      end
   end

   assign coin_return    = ret_q;
   assign call_terminate = term_q;
   assign call_enable    = (state == ST_TALK);
   assign out_of_order   = (state == ST_FAULT);

   AST_FAULT_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
      line_fault |=> (out_of_order && !call_enable));           // R8
   AST_ONHOOK_DROPS_CALL: assert property (@(posedge clk) disable iff (rst)
      !off_hook |=> !call_enable);                              // R7
   AST_TERM_AFTER_TALK: assert property (@(posedge clk) disable iff (rst)
      call_terminate |-> ($past(call_enable) && !call_enable)); // R6
   AST_RETURN_NEEDS_COIN: assert property (@(posedge clk) disable iff (rst)
      coin_return |-> $past(coin_is_held(state)));              // R3
   AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (rst)
      $fell(out_of_order) |-> $past(!line_fault && !off_hook)); // R9
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      call_terminate |=> !call_terminate);                      // R6

endmodule

// File: rtl/payphone_ctrl.sv
module payphone_ctrl #(
   parameter int SLOT_S    = 60,
   parameter int PROMPT_S  = 45,
   parameter bit COIN_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_1s,
   input  logic off_hook,
   input  logic coin_in,
   input  logic line_busy,
   input  logic line_connected,
   input  logic line_fault,
   output logic coin_return,
   output logic call_enable,
   output logic insert_coin_prompt,
   output logic call_terminate,
   output logic out_of_order
);
   if (SLOT_S < 2) begin : g_bad_slot
      $error("SLOT_S must be at least 2");
   end
   if (PROMPT_S < 1 || PROMPT_S >= SLOT_S) begin : g_bad_prompt
      $error("PROMPT_S must lie in 1 .. SLOT_S-1");
   end

   logic coin_evt;

   if (COIN_EDGE) begin : g_coin_edge
      logic coin_d;
      always_ff @(posedge clk) begin
         if (rst) coin_d <= 1'b0;
         else     coin_d <= coin_in;
      end
      assign coin_evt = coin_in & ~coin_d;
   end else begin : g_coin_level
      assign coin_evt = coin_in;
   end

   logic slot_run, slot_restart, slot_prompt, slot_expire;

   pp_slot_timer #(
      .SLOT_S   (SLOT_S),
      .PROMPT_S (PROMPT_S)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .run     (slot_run),
      .tick    (tick_1s),
      .restart (slot_restart),
      .prompt  (slot_prompt),
      .expire  (slot_expire)
   );

   pp_call_fsm u_fsm (
      .clk            (clk),
      .rst            (rst),
      .off_hook       (off_hook),
      .coin_evt       (coin_evt),
      .line_busy      (line_busy),
      .line_connected (line_connected),
      .line_fault     (line_fault),
      .slot_prompt    (slot_prompt),
      .slot_expire    (slot_expire),
      .slot_run       (slot_run),
      .slot_restart   (slot_restart),
      .coin_return    (coin_return),
      .call_enable    (call_enable),
      .call_terminate (call_terminate),
      .out_of_order   (out_of_order)
   );

   assign insert_coin_prompt = slot_prompt;

   AST_PROMPT_IN_CALL: assert property (@(posedge clk) disable iff (rst)
      insert_coin_prompt |-> call_enable);                      // R4
   AST_NO_CALL_WHEN_FAULT: assert property (@(posedge clk) disable iff (rst)
      !(out_of_order && (call_enable || call_terminate)));      // R8

endmodule

// File: tb/payphone_ctrl_test.sv
module payphone_ctrl_test;
   localparam int SLOT = 60;
   localparam int PRM  = 45;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_1s = 0, off_hook = 0, coin_in = 0;
   logic line_busy = 0, line_connected = 0, line_fault = 0;
   logic coin_return, call_enable, insert_coin_prompt, call_terminate, out_of_order;

   always #4 clk = ~clk;

   payphone_ctrl #(.SLOT_S(SLOT), .PROMPT_S(PRM), .COIN_EDGE(1'b1)) uut (
      .clk(clk), .rst(rst), .tick_1s(tick_1s), .off_hook(off_hook),
      .coin_in(coin_in), .line_busy(line_busy), .line_connected(line_connected),
      .line_fault(line_fault), .coin_return(coin_return), .call_enable(call_enable),
      .insert_coin_prompt(insert_coin_prompt), .call_terminate(call_terminate),
      .out_of_order(out_of_order)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string req    = "R1";

   // reference model: 0 idle, 1 need coin, 2 coin held, 3 busy, 4 talk, 5 done, 6 fault
   int m_st = 0, m_sec = 0;
   bit m_prev = 0, m_ret = 0, m_term = 0;

   always @(posedge clk) begin
      bit c;
      if (rst) begin
         m_st = 0; m_sec = 0; m_prev = 0; m_ret = 0; m_term = 0;
      end else begin
         c = coin_in && !m_prev;
         m_prev = coin_in;
         m_ret = 0; m_term = 0;
         if (line_fault) begin
            if (m_st == 2 || m_st == 3) m_ret = 1;
            m_st = 6; m_sec = 0;
         end else if (m_st == 6) begin
            if (!off_hook) m_st = 0;
         end else if (m_st == 0) begin
            if (off_hook) m_st = 1;
         end else if (!off_hook) begin
            if (m_st == 2 || m_st == 3) m_ret = 1;
            m_st = 0; m_sec = 0;
         end else if (m_st == 1) begin
            if (c) m_st = 2;
         end else if (m_st == 2) begin
            if (line_busy) m_st = 3;
            else if (line_connected) begin m_st = 4; m_sec = 0; end
         end else if (m_st == 4) begin
            if (c && m_sec >= PRM) m_sec = 0;
            else if (tick_1s) begin
               if (m_sec == SLOT - 1) begin m_st = 5; m_term = 1; m_sec = 0; end
               else m_sec++;
            end
         end
      end
   end

   always @(negedge clk) begin
      logic [4:0] act, exp_v;
      if (!done) begin
         act   = {coin_return, call_enable, insert_coin_prompt, call_terminate, out_of_order};
         exp_v = {m_ret, m_st == 4, (m_st == 4) && (m_sec >= PRM), m_term, m_st == 6};
         checks++;
         if (act !== exp_v) begin
            fails++;
            $display("FAIL %s t=%0t outputs(ret,en,prompt,term,ooo) actual=%b expected=%b",
                     req, $time, act, exp_v);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         tick_1s = 1; step(1);
         tick_1s = 0; step(1);
      end
   endtask

   task automatic coin(int len);
      coin_in = 1; step(len);
      coin_in = 0; step(1);
   endtask

   task automatic start_call();
      off_hook = 1; step(2);
      coin(1);
      line_connected = 1; step(1);
      line_connected = 0; step(1);
   endtask

   initial begin
      step(4);                                   // R1: outputs low in reset
      rst = 0;
      step(2);                                   // R1: idle after reset

      req = "R11";                               // coin and line while on-hook
      coin(1); line_connected = 1; step(2); line_connected = 0;
      off_hook = 1; step(2);
      line_connected = 1; step(3); line_connected = 0; step(1);

      req = "R2";                                // long coin counts once, then connect
      coin(4);
      req = "R10";                               // tick with connect is not counted
      line_connected = 1; tick_1s = 1; step(1);
      line_connected = 0; tick_1s = 0; step(1);
      req = "R5";                                // early coin ignored
      ticks(10); coin(1);
      req = "R4";
      ticks(PRM - 10); step(3);
      req = "R5";                                // coin under prompt restarts
      coin(1);
      ticks(SLOT - 1);
      req = "R10";                               // coin and last tick together
      coin_in = 1; tick_1s = 1; step(1);
      coin_in = 0; tick_1s = 0; step(2);
      req = "R6";
      ticks(SLOT); step(2);
      coin(1); line_connected = 1; step(3); line_connected = 0;
      ticks(3);
      off_hook = 0; step(3);

      req = "R3";
      off_hook = 1; step(2); coin(1);
      line_busy = 1; step(2); line_connected = 1; step(3);
      line_busy = 0; line_connected = 0; step(2);
      off_hook = 0; step(3);

      req = "R7";
      start_call(); ticks(5);
      off_hook = 0; step(3);

      req = "R8";                                // fault with coin held + on-hook same cycle
      off_hook = 1; step(2); coin(1); line_busy = 1; step(2);
      line_fault = 1; off_hook = 0; step(3);
      req = "R9";
      off_hook = 1; line_busy = 0; step(2);
      line_fault = 0; step(3);
      off_hook = 0; line_fault = 1; step(2);
      line_fault = 0; step(3);

      req = "R8";                                // fault during talk with on-hook
      start_call(); ticks(PRM + 1);
      line_fault = 1; off_hook = 0; step(2);
      line_fault = 0; step(3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog %s expired", req);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule